// File: doc/BRIEF.md
# Event Vector Dispatch Controller

This block keeps one programmable 32-bit handler address for each of sixteen core events, tracks which events are waiting or being serviced, and picks the next event to service. When it grants an event, it drives that entry's stored address, unchanged, as the next instruction-fetch target for one cycle and marks the event as in service. A later return strobe carrying the event number ends that service.

Software reaches the table and a read-only status word through a small register port. Addresses 0 to 15 select table entries and address 16 selects the status word. The status word has one bit per event, set while the event waits or is in service. Bit 4 is the exception: it shows the global interrupt disable flag, which only the controller's own set and clear inputs change. Lower event numbers win. An event is granted only if it outranks every event already in service. While the disable flag is 1, events 5 to 15 stay waiting and events 0 to 3 can still be granted.

The control is a two-state machine. In `S_IDLE` the block waits. The transition IDLE→GRANT is taken on the clock edge where some event is eligible, and the winning number is captured on that edge. During `S_GRANT` the fetch pulse is driven. The transition GRANT→IDLE is unconditional and marks the event as in service.

Top module: `evt_dispatch`

## Requirements
- R1: Register addresses 0 to 15 hold one 32-bit entry each, readable combinationally on `reg_rdata`. A write takes effect at the clock edge where `reg_wr` is sampled high. All entries reset to 0.
- R2: Register address 16 reads the status word. For each event n other than 4, bit n is 1 while n is waiting or in service. Bit 4 is the global disable flag. Bits 31 to 16 read 0.
- R3: After reset the status word reads 0x0000_0010 and `fetch_valid` is 0.
- R4: A 1 on `evt_raise[n]` in a cycle makes event n waiting from the next edge. `evt_raise[4]` has no effect.
- R5: An event raised alone while nothing is in service is granted with `fetch_valid` high in the second cycle after the raise cycle. The grant lasts exactly one cycle and carries `fetch_idx` = n and `fetch_addr` = entry n.
- R6: Among waiting, eligible events, the lowest number is granted first.
- R7: A waiting event is granted only if its number is lower than that of every event in service. Otherwise it keeps waiting.
- R8: `glob_dis_set` sets the disable flag and `glob_dis_clr` clears it at the next edge. Set wins when both are high. While the flag is 1, events 5 to 15 are not granted and events 0 to 3 are.
- R9: `ret_valid` with `ret_idx` = n ends service of n at the next edge. If n is not waiting again, its status bit then reads 0.
- R10: Writes to address 16 and to addresses 17 to 31 change neither the status word nor any table entry. Reads of addresses 17 to 31 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_raise | input | 16 | One bit per event; 1 marks the event waiting |
| ret_valid | input | 1 | Return-from-handler strobe |
| ret_idx | input | 4 | Event whose service ends |
| glob_dis_set | input | 1 | Set global disable flag |
| glob_dis_clr | input | 1 | Clear global disable flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address (0-15 table, 16 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| fetch_valid | output | 1 | One-cycle grant pulse |
| fetch_idx | output | 4 | Granted event number |
| fetch_addr | output | 32 | Handler address of granted event |

## Verification
The bench sweeps every event number through a raise, grant and return cycle and checks the exact grant cycle and address. A design that added a base-plus-offset calculation would return the wrong `fetch_addr`. A design that treated bit 4 as an event would show a status or grant after `evt_raise[4]`.

It also checks nesting:
- A higher-numbered event raised during service must stay waiting. A design that compared only against waiting events would preempt wrongly.
- A lower-numbered event must preempt.
- After the inner return, the outer event must still block.

The disable flag is exercised from both sides. Events 0 to 3 must be granted while it is set, event 8 must wait until it is cleared, and simultaneous set and clear must leave it set. Writes to the status address and to unmapped addresses must not disturb anything readable.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int EVT_N     = 16;
    localparam int ADDR_BITS = 32;
    localparam int GDIS_POS  = 4;
    localparam int MASK_LO   = 5;

    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_GRANT = 1'b1
    } disp_state_e;
endpackage

// File: rtl/evt_vec_table.sv
module evt_vec_table #(
    parameter int N     = 16,
    parameter int W     = 32,
    localparam int IW   = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_a_idx,
    output logic [W-1:0]  rd_a_data,
    input  logic [IW-1:0] rd_b_idx,
    output logic [W-1:0]  rd_b_data
);
    logic [W-1:0] ent_q [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ent_q[i] <= '0;
        end else if (wr_en) begin
            ent_q[wr_idx] <= wr_data;
        end
    end

    assign rd_a_data = ent_q[rd_a_idx];
    assign rd_b_data = ent_q[rd_b_idx];
endmodule

// File: rtl/evt_status_regs.sv
module evt_status_regs #(
    parameter int N       = 16,
    parameter int GPOS    = 4,
    localparam int IW     = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  raise,
    input  logic          grant_en,
    input  logic [IW-1:0] grant_idx,
    input  logic          ret_en,
    input  logic [IW-1:0] ret_idx,
    input  logic          gdis_set,
    input  logic          gdis_clr,
    output logic [N-1:0]  pend_q,
    output logic [N-1:0]  act_q,
    output logic          gdis_q
);
    logic [N-1:0] grant_oh, ret_oh, raise_m;

    always_comb begin
        grant_oh = grant_en ? (N'(1) << grant_idx) : '0;
        ret_oh   = ret_en   ? (N'(1) << ret_idx)   : '0;
        raise_m  = raise;
        raise_m[GPOS] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
            gdis_q <= 1'b1;
        end else begin
            pend_q <= (pend_q & ~grant_oh) | raise_m;
            act_q  <= (act_q & ~ret_oh) | grant_oh;
            if (gdis_set)      gdis_q <= 1'b1;
            else if (gdis_clr) gdis_q <= 1'b0;
        end
    end
endmodule

// File: rtl/evt_prio_select.sv
module evt_prio_select #(
    parameter int N       = 16,
    parameter int GPOS    = 4,
    parameter int MLO     = 5,
    localparam int IW     = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  act,
    input  logic          gdis,
    output logic          found,
    output logic [IW-1:0] sel_idx
);
    logic [N-1:0] blk, elig;

    for (genvar i = 0; i < N; i++) begin : g_elig
        if (i == 0) begin : g_first
            assign blk[i] = act[i];
        end else begin : g_rest
            assign blk[i] = blk[i-1] | act[i];
        end
        if (i == GPOS) begin : g_flag
            assign elig[i] = 1'b0;
        end else if (i >= MLO) begin : g_mask
            assign elig[i] = pend[i] & ~blk[i] & ~gdis;
        end else begin : g_nmask
            assign elig[i] = pend[i] & ~blk[i];
        end
    end

    always_comb begin
        sel_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) sel_idx = IW'(i);
        end
    end

    assign found = |elig;
endmodule

// File: rtl/evt_dispatch.sv
module evt_dispatch
    import evt_pkg::*;
#(
    parameter int NUM_EVT  = EVT_N,
    parameter int DATA_W   = ADDR_BITS,
    localparam int IDX_W   = $clog2(NUM_EVT),
    localparam int REG_AW  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EVT-1:0] evt_raise,
    input  logic              ret_valid,
    input  logic [IDX_W-1:0]  ret_idx,
    input  logic              glob_dis_set,
    input  logic              glob_dis_clr,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              fetch_valid,
    output logic [IDX_W-1:0]  fetch_idx,
    output logic [DATA_W-1:0] fetch_addr
);
    localparam int STAT_ADDR = NUM_EVT;

    disp_state_e        state_q, state_d;
    logic [IDX_W-1:0]   idx_q;
    logic [NUM_EVT-1:0] pend_q, act_q;
    logic               gdis_q;
    logic               cand_found;
    logic [IDX_W-1:0]   cand_idx;
    logic [DATA_W-1:0]  tbl_rd, tbl_fetch, stat_w;
    logic               in_table;

    assign in_table = (reg_addr < REG_AW'(NUM_EVT));

    evt_vec_table #(.N(NUM_EVT), .W(DATA_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr & in_table),
        .wr_idx    (reg_addr[IDX_W-1:0]),
        .wr_data   (reg_wdata),
        .rd_a_idx  (reg_addr[IDX_W-1:0]),
        .rd_a_data (tbl_rd),
        .rd_b_idx  (idx_q),
        .rd_b_data (tbl_fetch)
    );

    evt_status_regs #(.N(NUM_EVT), .GPOS(GDIS_POS)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .raise     (evt_raise),
        .grant_en  (fetch_valid),
        .grant_idx (idx_q),
        .ret_en    (ret_valid),
        .ret_idx   (ret_idx),
        .gdis_set  (glob_dis_set),
        .gdis_clr  (glob_dis_clr),
        .pend_q    (pend_q),
        .act_q     (act_q),
        .gdis_q    (gdis_q)
    );

    evt_prio_select #(.N(NUM_EVT), .GPOS(GDIS_POS), .MLO(MASK_LO)) u_prio (
        .pend    (pend_q),
        .act     (act_q),
        .gdis    (gdis_q),
        .found   (cand_found),
        .sel_idx (cand_idx)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (cand_found) state_d = S_GRANT;
            S_GRANT: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && cand_found) idx_q <= cand_idx;
        end
    end

    // outputs
    always_comb begin
        fetch_valid = 1'b0;
        fetch_idx   = idx_q;
        fetch_addr  = '0;
        unique case (state_q)
            S_IDLE:  ;
            S_GRANT: begin
                fetch_valid = 1'b1;
                fetch_addr  = tbl_fetch;
            end
        endcase
    end

    always_comb begin
        stat_w = '0;
        stat_w[NUM_EVT-1:0] = pend_q | act_q;
        stat_w[GDIS_POS]    = gdis_q;
    end

    always_comb begin
        if (in_table)                             reg_rdata = tbl_rd;
        else if (reg_addr == REG_AW'(STAT_ADDR))  reg_rdata = stat_w;
        else                                      reg_rdata = '0;
    end
endmodule

// File: rtl/evt_dispatch_chk.sv
module evt_dispatch_chk #(
    parameter int NUM_EVT = 16,
    parameter int DATA_W  = 32,
    parameter int GPOS    = 4,
    parameter int MLO     = 5,
    localparam int IDX_W  = $clog2(NUM_EVT),
    localparam int REG_AW = IDX_W + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fetch_valid,
    input logic [IDX_W-1:0]   fetch_idx,
    input logic               ret_valid,
    input logic [IDX_W-1:0]   ret_idx,
    input logic               glob_dis_set,
    input logic [NUM_EVT-1:0] act_q,
    input logic               gdis_q,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_rdata
);
    logic [NUM_EVT:0] upto_mask;
    assign upto_mask = ((NUM_EVT+1)'(1) << (fetch_idx + 1'b1)) - 1'b1;

    // R5
    grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> !fetch_valid);

    // R7
    grant_outranks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> ((act_q & upto_mask[NUM_EVT-1:0]) == '0));

    // R8
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && (fetch_idx >= IDX_W'(MLO))) |-> !$past(gdis_q));

    // R8
    gdis_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        glob_dis_set |=> gdis_q);

    // R9
    ret_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !(fetch_valid && fetch_idx == ret_idx)) |=> !act_q[$past(ret_idx)]);

    // R2
    stat_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == REG_AW'(NUM_EVT)) |-> (reg_rdata[DATA_W-1:NUM_EVT] == '0));

    // R4
    flag_bit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_q[GPOS]);
endmodule

bind evt_dispatch evt_dispatch_chk #(
    .NUM_EVT (NUM_EVT),
    .DATA_W  (DATA_W),
    .GPOS    (evt_pkg::GDIS_POS),
    .MLO     (evt_pkg::MASK_LO)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_valid  (fetch_valid),
    .fetch_idx    (fetch_idx),
    .ret_valid    (ret_valid),
    .ret_idx      (ret_idx),
    .glob_dis_set (glob_dis_set),
    .act_q        (act_q),
    .gdis_q       (gdis_q),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata)
);

// File: tb/test_evt_dispatch.sv
module test_evt_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 16;
    localparam int IW = 4;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt_raise = '0;
    logic          ret_valid = 1'b0;
    logic [IW-1:0] ret_idx = '0;
    logic          glob_dis_set = 1'b0;
    logic          glob_dis_clr = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          fetch_valid;
    logic [IW-1:0] fetch_idx;
    logic [31:0]   fetch_addr;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] tbl_m [NE];

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_dispatch i_evt_dispatch (
        .clk(clk), .rst_n(rst_n), .evt_raise(evt_raise),
        .ret_valid(ret_valid), .ret_idx(ret_idx),
        .glob_dis_set(glob_dis_set), .glob_dis_clr(glob_dis_clr),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
        .fetch_idx(fetch_idx), .fetch_addr(fetch_addr)
    );

    function automatic logic [31:0] exp_addr(input int i);
        return 32'hC000_0000 | (32'(i) << 12) | (32'(i) << 2);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = AW'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic raise(input logic [NE-1:0] m);
        evt_raise = m;
        @(negedge clk);
        evt_raise = '0;
    endtask

    task automatic ret(input int i);
        ret_valid = 1'b1; ret_idx = IW'(i);
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    task automatic wait_grant(input int i, input string tag);
        int k = 0;
        while (!fetch_valid && k < 8) begin
            @(negedge clk);
            k++;
        end
        chk({tag, " grant seen"}, 32'(fetch_valid), 32'd1);
        chk({tag, " idx"}, 32'(fetch_idx), 32'(i));
        chk({tag, " addr"}, fetch_addr, tbl_m[i]);
        @(negedge clk);
    endtask

    task automatic wait_none(input int n, input string tag);
        int seen = 0;
        for (int k = 0; k < n; k++) begin
            if (fetch_valid) seen = 1;
            @(negedge clk);
        end
        chk({tag, " no grant"}, 32'(seen), 32'd0);
    endtask

    task automatic stat(input logic [31:0] exp, input string tag);
        logic [31:0] d;
        rd(16, d);
        chk({tag, " status"}, d, exp);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state
        stat(32'h10, "R3");
        chk("R3 fetch_valid", 32'(fetch_valid), 32'd0);
        rd(7, d); chk("R1 entry reset", d, 32'd0);

        // R1 program and read back every entry
        for (int i = 0; i < NE; i++) begin
            tbl_m[i] = exp_addr(i);
            wr(i, tbl_m[i]);
        end
        for (int i = 0; i < NE; i++) begin
            rd(i, d); chk($sformatf("R1 entry %0d", i), d, tbl_m[i]);
        end

        // R10 writes to status and unmapped addresses ignored
        wr(16, 32'hFFFF_FFFF);
        stat(32'h10, "R10");
        for (int a = 17; a < 32; a++) wr(a, 32'h5A5A_5A5A);
        for (int a = 17; a < 32; a++) begin
            rd(a, d); chk($sformatf("R10 unmapped %0d", a), d, 32'd0);
        end
        for (int i = 0; i < NE; i++) begin
            rd(i, d); chk($sformatf("R10 entry %0d intact", i), d, tbl_m[i]);
        end

        // R8 flag set: events 0..3 still granted, 8 held
        for (int i = 0; i < 4; i++) begin
            raise(NE'(1) << i);
            wait_grant(i, "R8 unmaskable");
            ret(i);
        end
        raise(NE'(1) << 8);
        wait_none(6, "R8 masked");
        stat(32'h110, "R8 held");
        glob_dis_clr = 1'b1; @(negedge clk); glob_dis_clr = 1'b0;
        wait_grant(8, "R8 after clear");
        ret(8);
        stat(32'h0, "R9 after ret 8");

        // R5 R2 R9 sweep with flag clear
        for (int i = 0; i < NE; i++) begin
            if (i == 4) continue;
            raise(NE'(1) << i);
            @(negedge clk);
            chk($sformatf("R5 latency %0d", i), 32'(fetch_valid), 32'd1);
            chk($sformatf("R5 idx %0d", i), 32'(fetch_idx), 32'(i));
            chk($sformatf("R5 addr %0d", i), fetch_addr, tbl_m[i]);
            @(negedge clk);
            chk($sformatf("R5 single pulse %0d", i), 32'(fetch_valid), 32'd0);
            stat(32'd1 << i, $sformatf("R2 event %0d", i));
            ret(i);
            stat(32'd0, $sformatf("R9 event %0d", i));
        end

        // R4 raise of flag bit has no effect
        raise(NE'(1) << 4);
        wait_none(6, "R4");
        stat(32'h0, "R4");

        // R6 lowest first, R7 blocked by active
        raise(NE'(16'h0A40));
        wait_grant(6, "R6 first");
        stat(32'h0A40, "R6");
        wait_none(5, "R7 blocked by 6");
        ret(6);
        wait_grant(9, "R6 second");
        ret(9);
        wait_grant(11, "R6 third");
        ret(11);
        stat(32'h0, "R9 all done");

        // R7 nesting
        raise(NE'(1) << 10);
        wait_grant(10, "R7 outer");
        raise(NE'(1) << 12);
        wait_none(5, "R7 higher number waits");
        raise(NE'(1) << 2);
        wait_grant(2, "R7 preempt");
        ret(2);
        wait_none(5, "R7 outer still blocks");
        ret(10);
        wait_grant(12, "R7 released");
        ret(12);
        stat(32'h0, "R7 end");

        // R8 set wins over clear
        glob_dis_set = 1'b1; glob_dis_clr = 1'b1;
        @(negedge clk);
        glob_dis_set = 1'b0; glob_dis_clr = 1'b0;
        stat(32'h10, "R8 set wins");

        // R1 rewrite takes effect for next grant
        tbl_m[3] = 32'h1234_5678;
        wr(3, tbl_m[3]);
        raise(NE'(1) << 3);
        wait_grant(3, "R1 rewritten");
        ret(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule